// File: doc/BRIEF.md
# Burst Chip and Symbol Strobe Timer

This block produces the transmit timing of a direct-sequence spread-spectrum modem. The chip-rate strobe comes from one of two sources. The first is an internal divider of the master clock. The second is the rising edge of an external chip reference, brought into the clock domain through a two-flop synchronizer. Chip strobes are counted into symbol strobes, with a programmed number of chips per symbol, so that symbol boundaries stay locked to the spreading code.

A 16-bit symbols-per-burst counter limits each burst. A start pulse opens a burst and captures the configuration. After the programmed number of symbols, the timer stops by itself and reports the end with a one-cycle done pulse. It then stays silent until the next start. Transmit timing depends on nothing from the receive side, so the two sides may run from unrelated clocks.

Top module: `burst_timer`

## Requirements
- R1: After reset, all four outputs are low and the timer is idle.
- R2: With the internal source and divider value N, the chip strobe is high for one cycle in every Nth cycle of a burst. The first chip strobe comes N cycles after the clock edge that accepts the start pulse.
- R3: With chips-per-symbol value M, the symbol strobe is high together with every Mth chip strobe of the burst, counting from the first chip strobe. The symbol strobe is never high without a chip strobe.
- R4: With symbols-per-burst value B, the burst-active output rises one cycle after start is accepted. It stays high through the cycle of the Bth symbol strobe, then goes low. No chip or symbol strobe appears while the timer is idle.
- R5: The burst-done output is high for exactly the one cycle that follows the last symbol strobe of a burst.
- R6: A value of 0 for the divider, the chips-per-symbol value or the symbols-per-burst value behaves exactly like a value of 1.
- R7: With the external-source select high, each rising edge of the external reference gives one chip strobe during a burst. The strobe is high for the one cycle that follows the second clock edge sampling the reference high. The internal divider value then has no effect.
- R8: All configuration inputs are captured when a start is accepted. Configuration changes during a burst have no effect, and a start pulse during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | 16 | Master clocks per chip (internal source) |
| cfg_chips_i | input | 16 | Chips per symbol |
| cfg_syms_i | input | 16 | Symbols per burst |
| cfg_ext_sel_i | input | 1 | 1 selects the external chip reference |
| start_i | input | 1 | Starts a burst when idle |
| ext_ref_i | input | 1 | External chip-rate reference, asynchronous |
| chip_stb_o | output | 1 | One-cycle chip strobe |
| sym_stb_o | output | 1 | One-cycle symbol strobe |
| burst_active_o | output | 1 | High while a burst runs |
| burst_done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The assertions assume three things about the inputs. The configuration is sampled only at an accepted start. In the external mode, the reference stays high for at least two clock cycles and low for at least two between edges, so the synchronizer sees every edge. Start is driven synchronously. The stimulus keeps to these assumptions. It drives the inputs on the falling clock edge and runs the external reference as a two-high, two-low square wave. It changes the configuration and pulses start during a burst only to check that they are ignored.

// File: rtl/burst_timer_pkg.sv
package burst_timer_pkg;
  localparam int unsigned CFG_W = 16;

  typedef logic [CFG_W-1:0] cfg_t;

  // zero means one
  function automatic cfg_t eff_limit(input cfg_t raw);
    return (raw == '0) ? cfg_t'(1) : raw;
  endfunction

  // count reaches the final value of a cycle of length raw
  function automatic logic is_terminal(input cfg_t cnt, input cfg_t raw);
    return cnt == (eff_limit(raw) - cfg_t'(1));
  endfunction
endpackage

// File: rtl/bt_wrap_counter.sv
module bt_wrap_counter
  import burst_timer_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = is_terminal(cfg_t'(cnt_q), cfg_t'(limit_i));
  assign wrap_o = adv_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (adv_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_t'(cnt_q) < eff_limit(cfg_t'(limit_i)) || $changed(limit_i) || clr_i || $past(clr_i));
endmodule

// File: rtl/bt_chip_gen.sv
module bt_chip_gen
  import burst_timer_pkg::*;
#(
  parameter int unsigned W       = CFG_W,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         ext_sel_i,
  input  logic [W-1:0] div_i,
  input  logic         ext_ref_i,
  output logic         chip_stb_o
);
  logic [SYNC_FF-1:0] sync_q;
  logic               ref_prev_q;
  logic               ext_edge;
  logic               div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ref_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_FF-2:0], ext_ref_i};
      ref_prev_q <= sync_q[SYNC_FF-1];
    end
  end

  assign ext_edge = sync_q[SYNC_FF-1] & ~ref_prev_q;

  bt_wrap_counter #(.W(W)) div_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .adv_i  (run_i & ~ext_sel_i),
    .limit_i(div_i),
    .wrap_o (div_wrap)
  );

  assign chip_stb_o = run_i & (ext_sel_i ? ext_edge : div_wrap);

  assert_ext_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
  assert_div_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb_o && !ext_sel_i && div_i > 1 && $stable(div_i)) |=> !chip_stb_o);
endmodule

// File: rtl/burst_timer.sv
module burst_timer
  import burst_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_div_i,
  input  logic [CFG_W-1:0] cfg_chips_i,
  input  logic [CFG_W-1:0] cfg_syms_i,
  input  logic             cfg_ext_sel_i,
  input  logic             start_i,
  input  logic             ext_ref_i,
  output logic             chip_stb_o,
  output logic             sym_stb_o,
  output logic             burst_active_o,
  output logic             burst_done_o
);
  cfg_t div_q, chips_q, syms_q;
  logic ext_sel_q;
  logic active_q, done_q;
  logic start_acc;
  logic chip_stb, sym_stb, burst_wrap, last_sym;

  assign start_acc = start_i & ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      chips_q   <= '0;
      syms_q    <= '0;
      ext_sel_q <= 1'b0;
    end else if (start_acc) begin
      div_q     <= cfg_div_i;
      chips_q   <= cfg_chips_i;
      syms_q    <= cfg_syms_i;
      ext_sel_q <= cfg_ext_sel_i;
    end
  end

  bt_chip_gen #(.W(CFG_W)) chip_gen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (active_q),
    .clr_i     (start_acc),
    .ext_sel_i (ext_sel_q),
    .div_i     (div_q),
    .ext_ref_i (ext_ref_i),
    .chip_stb_o(chip_stb)
  );

  bt_wrap_counter #(.W(CFG_W)) sym_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_acc),
    .adv_i  (chip_stb),
    .limit_i(chips_q),
    .wrap_o (sym_stb)
  );

  bt_wrap_counter #(.W(CFG_W)) burst_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_acc),
    .adv_i  (sym_stb),
    .limit_i(syms_q),
    .wrap_o (burst_wrap)
  );

  assign last_sym = burst_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_sym;
      if (start_acc)     active_q <= 1'b1;
      else if (last_sym) active_q <= 1'b0;
    end
  end

  assign chip_stb_o     = chip_stb;
  assign sym_stb_o      = sym_stb;
  assign burst_active_o = active_q;
  assign burst_done_o   = done_q;

  assert_sym_needs_chip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb_o |-> chip_stb_o);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active_o |-> (!chip_stb_o && !sym_stb_o));
  assert_done_follows_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active_o) |-> burst_done_o);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_o |-> (!burst_active_o && $past(sym_stb_o)));
  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active_o && $past(burst_active_o)) |-> ($stable(div_q) && $stable(syms_q) && $stable(chips_q)));
endmodule

// File: tb/burst_timer_tb_top.sv
module burst_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = '0, cfg_chips = '0, cfg_syms = '0;
  logic        cfg_ext = 1'b0, start = 1'b0, ext_ref = 1'b0;
  logic        chip_stb, sym_stb, active, done;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  int act_lo = 1, act_hi = 0;
  bit finished = 0;

  typedef struct { int at; logic [2:0] code; string tag; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_div_i(cfg_div), .cfg_chips_i(cfg_chips), .cfg_syms_i(cfg_syms),
    .cfg_ext_sel_i(cfg_ext), .start_i(start), .ext_ref_i(ext_ref),
    .chip_stb_o(chip_stb), .sym_stb_o(sym_stb),
    .burst_active_o(active), .burst_done_o(done)
  );

  function automatic int one_if_zero(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // monitor: code = {done, sym, chip}
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [2:0] obs;
      item_t it;
      obs = {done, sym_stb, chip_stb};
      n_cmp++;
      if (active !== (cyc >= act_lo && cyc <= act_hi)) begin
        n_bad++;
        $display("FAIL R4 cyc %0d: active actual %b expected %b", cyc, active, (cyc >= act_lo && cyc <= act_hi));
      end
      if (obs != 3'b000) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R4 cyc %0d: unexpected event actual %b expected none", cyc, obs);
        end else begin
          it = exp_q.pop_front();
          if (it.at != cyc || it.code != obs) begin
            n_bad++;
            $display("FAIL %s: actual cyc %0d code %b expected cyc %0d code %b", it.tag, cyc, obs, it.at, it.code);
          end
        end
      end else if (exp_q.size() != 0 && exp_q[0].at <= cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: actual none at cyc %0d expected code %b", exp_q[0].tag, cyc, exp_q[0].code);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic push_burst(input int c0, input int n, input int m, input int b, input string tag);
    item_t it;
    for (int k = 1; k <= b * m; k++) begin
      it.at = c0 + k * n;
      it.code = {1'b0, (k % m == 0), 1'b1};
      it.tag = tag;
      exp_q.push_back(it);
    end
    it.at = c0 + b * m * n + 1; it.code = 3'b100; it.tag = {tag, "/R5"};
    exp_q.push_back(it);
    act_lo = c0 + 1; act_hi = c0 + b * m * n;
  endtask

  task automatic drain(input string tag);
    while (cyc <= act_hi + 3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: pending events actual %0d expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // internal-source burst, optionally disturbed mid-burst
  task automatic run_int(input int n, input int m, input int b, input bit disturb, input string tag);
    int c0;
    @(negedge clk);
    cfg_ext = 1'b0; cfg_div = 16'(n); cfg_chips = 16'(m); cfg_syms = 16'(b);
    c0 = cyc;
    push_burst(c0, one_if_zero(n), one_if_zero(m), one_if_zero(b), tag);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      cfg_div = 16'd1; cfg_chips = 16'd1; cfg_syms = 16'd9; cfg_ext = 1'b1;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    drain(tag);
  endtask

  task automatic run_ext(input int m, input int b, input string tag);
    int c0;
    item_t it;
    @(negedge clk);
    cfg_ext = 1'b1; cfg_div = 16'd50; cfg_chips = 16'(m); cfg_syms = 16'(b);
    c0 = cyc;
    for (int p = 0; p < b * m; p++) begin
      it.at = c0 + 5 + 4 * p;
      it.code = {1'b0, ((p + 1) % m == 0), 1'b1};
      it.tag = tag;
      exp_q.push_back(it);
    end
    it.at = c0 + 2 + 4 * b * m; it.code = 3'b100; it.tag = {tag, "/R5"};
    exp_q.push_back(it);
    act_lo = c0 + 1; act_hi = c0 + 1 + 4 * b * m;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int p = 0; p < b * m; p++) begin
      repeat (2) @(negedge clk);
      ext_ref = 1'b1;
      repeat (2) @(negedge clk);
      ext_ref = 1'b0;
    end
    drain(tag);
    cfg_ext = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({chip_stb, sym_stb, active, done} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: outputs actual %b expected 0000", {chip_stb, sym_stb, active, done});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_cmp++;
    if ({chip_stb, sym_stb, active, done} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: idle outputs actual %b expected 0000", {chip_stb, sym_stb, active, done});
    end
    run_int(3, 4, 2, 1'b0, "R2/R3/R4");
    run_int(1, 1, 3, 1'b0, "R2_div1");
    run_int(2, 3, 1, 1'b0, "R3_single");
    run_int(0, 0, 0, 1'b0, "R6_zero");
    run_int(0, 2, 2, 1'b0, "R6_div0");
    run_int(4, 2, 2, 1'b1, "R8_locked");
    run_ext(2, 2, "R7_ext");
    run_ext(1, 1, "R7_ext1");
    run_int(2, 2, 1, 1'b0, "R7_back_internal");
    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule